// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a logical address, a segment number plus an offset, into a physical address. The segment descriptors live in internal registers. Each descriptor holds a base, a limit, a present flag and three permission flags. A separate length register sets how many segment numbers are legal. Software loads descriptors through a one-cycle write port and sets the length through its own write strobe.

Each request carries an access kind: read, write or execute. After one registered cycle the unit returns either the translated address with a zero cause, or a fault cause code with the address forced to zero. The checks run in a fixed order: length, present flag, limit, permission. Only the first failing check is reported.

Both sides use a valid/ready handshake. A response that is not taken is held steady, and the request side stalls until it is taken.

Top module: `seg_xlate`

## Requirements
- R1: After reset every descriptor is absent (present flag 0), the length register is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request whose segment number is greater than or equal to the length register returns cause 1, whatever that descriptor contains.
- R3: A request to a legal segment whose present flag is 0 returns cause 2.
- R4: A request to a present descriptor whose offset is greater than or equal to its limit returns cause 3. The limit is OFS_W+1 bits wide, so a limit of 2^OFS_W admits every offset.
- R5: The access kind code is 0 for read, 1 for write and 2 for execute. These need permission bit 0, bit 1 and bit 2 respectively. Code 3 is reserved and always denied. A missing permission returns cause 4.
- R6: When every check passes, the cause is 0 and `rsp_paddr` is base plus offset, taken modulo 2^PA_W.
- R7: Whenever the cause is non-zero, `rsp_paddr` is 0.
- R8: When several checks fail, only the first in the order length, present, limit, permission is reported. Cause values never exceed 4.
- R9: A request accepted on a clock edge (`req_valid` and `req_ready` both high) produces `rsp_valid` high after that edge. `req_ready` is high exactly when no response is pending or the pending one is being taken.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_cause` hold their values.
- R11: A descriptor or length write takes effect for requests accepted on later edges. A request accepted on the same edge as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Descriptor write strobe |
| tbl_wr_idx | input | SEG_W | Descriptor index written |
| tbl_wr_base | input | PA_W | Segment base address |
| tbl_wr_limit | input | OFS_W+1 | Segment length |
| tbl_wr_present | input | 1 | Present flag |
| tbl_wr_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| len_wr_en | input | 1 | Length register write strobe |
| len_wr_val | input | SEG_W+1 | Number of legal segments |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_seg | input | SEG_W | Segment number |
| req_ofs | input | OFS_W | Offset inside the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with `rsp_valid` |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_cause | output | 3 | 0 none, 1 out of range, 2 absent, 3 over limit, 4 denied |

## Verification
The bench builds the unit with SEG_W=3, OFS_W=6 and PA_W=10. With an 8-entry table and 64-byte segments, random segment numbers fall on either side of the length register often. Random offsets also hit the limit boundary, including the full-range limit of 64. A 10-bit physical space lets base plus offset wrap, so the modulo rule gets exercised. The small widths also make fault combinations that test the ordering frequent in random traffic.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_RANGE   = 3'd1,
      CAUSE_ABSENT  = 3'd2,
      CAUSE_LIMIT   = 3'd3,
      CAUSE_DENIED  = 3'd4
   } cause_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int PERM_W   = 3;
   localparam int PERM_RD  = 0;
   localparam int PERM_WR  = 1;
   localparam int PERM_EX  = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_W  = 3,
   parameter int PA_W   = 16,
   parameter int LIM_W  = 13
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [SEG_W-1:0]                    wr_idx,
   input  logic [PA_W-1:0]                     wr_base,
   input  logic [LIM_W-1:0]                    wr_limit,
   input  logic                                wr_present,
   input  logic [seg_xlate_pkg::PERM_W-1:0]    wr_perm,
   input  logic                                len_en,
   input  logic [SEG_W:0]                      len_val,
   input  logic [SEG_W-1:0]                    rd_idx,
   output logic [PA_W-1:0]                     rd_base,
   output logic [LIM_W-1:0]                    rd_limit,
   output logic                                rd_present,
   output logic [seg_xlate_pkg::PERM_W-1:0]    rd_perm,
   output logic [SEG_W:0]                      seg_len
);
   localparam int NSEG = 1 << SEG_W;
   localparam int PW   = seg_xlate_pkg::PERM_W;

   logic [PA_W-1:0]  base_q    [NSEG];
   logic [LIM_W-1:0] limit_q   [NSEG];
   logic             present_q [NSEG];
   logic [PW-1:0]    perm_q    [NSEG];
   logic [SEG_W:0]   len_q;

   for (genvar e = 0; e < NSEG; e++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_idx == SEG_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[e]    <= '0;
            limit_q[e]   <= '0;
            present_q[e] <= 1'b0;
            perm_q[e]    <= '0;
         end else if (hit) begin
            base_q[e]    <= wr_base;
            limit_q[e]   <= wr_limit;
            present_q[e] <= wr_present;
            perm_q[e]    <= wr_perm;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '0;
      else if (len_en) len_q <= len_val;
   end

   assign rd_base    = base_q[rd_idx];
   assign rd_limit   = limit_q[rd_idx];
   assign rd_present = present_q[rd_idx];
   assign rd_perm    = perm_q[rd_idx];
   assign seg_len    = len_q;

endmodule

// File: rtl/seg_check.sv
module seg_check #(
   parameter int SEG_W  = 3,
   parameter int OFS_W  = 12,
   parameter int PA_W   = 16,
   parameter int LIM_W  = 13
) (
   input  logic [SEG_W-1:0]                    seg,
   input  logic [OFS_W-1:0]                    ofs,
   input  logic [1:0]                          acc,
   input  logic [SEG_W:0]                      seg_len,
   input  logic [PA_W-1:0]                     base,
   input  logic [LIM_W-1:0]                    limit,
   input  logic                                present,
   input  logic [seg_xlate_pkg::PERM_W-1:0]    perm,
   output logic [2:0]                          cause,
   output logic [PA_W-1:0]                     paddr
);
   import seg_xlate_pkg::*;

   logic in_range, over_limit, allowed;
   logic [PA_W-1:0] sum;

   assign in_range   = {1'b0, seg} < seg_len;
   assign over_limit = {1'b0, ofs} >= limit;

   always_comb begin
      unique case (acc_e'(acc))
         ACC_READ:  allowed = perm[PERM_RD];
         ACC_WRITE: allowed = perm[PERM_WR];
         ACC_EXEC:  allowed = perm[PERM_EX];
         default:   allowed = 1'b0;
      endcase
   end

   if (PA_W > OFS_W) begin : g_wide
      assign sum = base + {{(PA_W-OFS_W){1'b0}}, ofs};
   end else begin : g_same
      assign sum = base + ofs;
   end

   always_comb begin
      if (!in_range)      cause = CAUSE_RANGE;
      else if (!present)  cause = CAUSE_ABSENT;
      else if (over_limit) cause = CAUSE_LIMIT;
      else if (!allowed)  cause = CAUSE_DENIED;
      else                cause = CAUSE_NONE;
   end

   assign paddr = (cause == CAUSE_NONE) ? sum : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
   parameter int SEG_W  = 3,
   parameter int OFS_W  = 12,
   parameter int PA_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tbl_wr_en,
   input  logic [SEG_W-1:0]   tbl_wr_idx,
   input  logic [PA_W-1:0]    tbl_wr_base,
   input  logic [OFS_W:0]     tbl_wr_limit,
   input  logic               tbl_wr_present,
   input  logic [2:0]         tbl_wr_perm,
   input  logic               len_wr_en,
   input  logic [SEG_W:0]     len_wr_val,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFS_W-1:0]   req_ofs,
   input  logic [1:0]         req_acc,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [2:0]         rsp_cause
);
   localparam int LIM_W = OFS_W + 1;
   localparam int PW    = seg_xlate_pkg::PERM_W;

   if (SEG_W < 1 || SEG_W > 8) begin : g_bad_seg
      $error("seg_xlate: SEG_W must lie in 1..8");
   end
   if (OFS_W < 1) begin : g_bad_ofs
      $error("seg_xlate: OFS_W must be at least 1");
   end
   if (PA_W < OFS_W) begin : g_bad_pa
      $error("seg_xlate: PA_W must not be narrower than OFS_W");
   end

   logic [PA_W-1:0]  e_base;
   logic [LIM_W-1:0] e_limit;
   logic             e_present;
   logic [PW-1:0]    e_perm;
   logic [SEG_W:0]   cur_len;
   logic [2:0]       c_cause;
   logic [PA_W-1:0]  c_paddr;

   seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_tbl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (tbl_wr_en),
      .wr_idx     (tbl_wr_idx),
      .wr_base    (tbl_wr_base),
      .wr_limit   (tbl_wr_limit),
      .wr_present (tbl_wr_present),
      .wr_perm    (tbl_wr_perm),
      .len_en     (len_wr_en),
      .len_val    (len_wr_val),
      .rd_idx     (req_seg),
      .rd_base    (e_base),
      .rd_limit   (e_limit),
      .rd_present (e_present),
      .rd_perm    (e_perm),
      .seg_len    (cur_len)
   );

   seg_check #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_chk_logic (
      .seg     (req_seg),
      .ofs     (req_ofs),
      .acc     (req_acc),
      .seg_len (cur_len),
      .base    (e_base),
      .limit   (e_limit),
      .present (e_present),
      .perm    (e_perm),
      .cause   (c_cause),
      .paddr   (c_paddr)
   );

   logic            vld_q;
   logic [PA_W-1:0] paddr_q;
   logic [2:0]      cause_q;
   logic            accept;

   assign req_ready = !vld_q || rsp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         paddr_q <= '0;
         cause_q <= '0;
      end else if (accept) begin
         vld_q   <= 1'b1;
         paddr_q <= c_paddr;
         cause_q <= c_cause;
      end else if (rsp_ready) begin
         vld_q   <= 1'b0;
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_paddr = paddr_q;
   assign rsp_cause = cause_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int SEG_W  = 3,
   parameter int OFS_W  = 12,
   parameter int PA_W   = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [PA_W-1:0]  rsp_paddr,
   input logic [2:0]       rsp_cause
);
   // R7
   fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_cause != 3'd0) |-> rsp_paddr == '0);

   // R8
   cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_cause <= 3'd4);

   // R9
   accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R9
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> req_ready);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause)));

   // R10
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_paddr (rsp_paddr),
   .rsp_cause (rsp_cause)
);

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;
   localparam int SEG_W = 3;
   localparam int OFS_W = 6;
   localparam int PA_W  = 10;
   localparam int NSEG  = 1 << SEG_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbl_wr_en = 1'b0;
   logic [SEG_W-1:0] tbl_wr_idx = '0;
   logic [PA_W-1:0] tbl_wr_base = '0;
   logic [OFS_W:0] tbl_wr_limit = '0;
   logic tbl_wr_present = 1'b0;
   logic [2:0] tbl_wr_perm = '0;
   logic len_wr_en = 1'b0;
   logic [SEG_W:0] len_wr_val = '0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [SEG_W-1:0] req_seg = '0;
   logic [OFS_W-1:0] req_ofs = '0;
   logic [1:0] req_acc = '0;
   logic rsp_valid;
   logic rsp_ready = 1'b1;
   logic [PA_W-1:0] rsp_paddr;
   logic [2:0] rsp_cause;

   int checks = 0;
   int failures = 0;

   logic [PA_W-1:0] m_base [NSEG];
   logic [OFS_W:0]  m_lim  [NSEG];
   logic            m_pres [NSEG];
   logic [2:0]      m_perm [NSEG];
   logic [SEG_W:0]  m_len;

   always #2.5 clk = ~clk;

   seg_xlate #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) i_seg_xlate (.*);

   task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_cause(logic [SEG_W-1:0] s, logic [OFS_W-1:0] o, logic [1:0] a);
      if ({1'b0, s} >= m_len) return 3'd1;
      if (!m_pres[s]) return 3'd2;
      if ({1'b0, o} >= m_lim[s]) return 3'd3;
      if (a == 2'd3 || !m_perm[s][a]) return 3'd4;
      return 3'd0;
   endfunction

   function automatic logic [PA_W-1:0] exp_addr(logic [SEG_W-1:0] s, logic [OFS_W-1:0] o, logic [1:0] a);
      if (exp_cause(s, o, a) != 3'd0) return '0;
      return PA_W'(m_base[s] + PA_W'(o));
   endfunction

   task automatic wr_ent(int idx, int base, int lim, bit pres, int perm);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = SEG_W'(idx); tbl_wr_base = PA_W'(base);
      tbl_wr_limit = (OFS_W+1)'(lim); tbl_wr_present = pres; tbl_wr_perm = 3'(perm);
      @(posedge clk);
      #1 tbl_wr_en = 1'b0;
      m_base[idx] = PA_W'(base); m_lim[idx] = (OFS_W+1)'(lim);
      m_pres[idx] = pres; m_perm[idx] = 3'(perm);
   endtask

   task automatic wr_len(int v);
      @(negedge clk);
      len_wr_en = 1'b1; len_wr_val = (SEG_W+1)'(v);
      @(posedge clk);
      #1 len_wr_en = 1'b0;
      m_len = (SEG_W+1)'(v);
   endtask

   task automatic do_req(string rq, int s, int o, int a);
      logic [2:0] ec;
      logic [PA_W-1:0] ea;
      @(negedge clk);
      req_valid = 1'b1; req_seg = SEG_W'(s); req_ofs = OFS_W'(o); req_acc = 2'(a);
      rsp_ready = 1'b1;
      ec = exp_cause(req_seg, req_ofs, req_acc);
      ea = exp_addr(req_seg, req_ofs, req_acc);
      @(negedge clk);
      req_valid = 1'b0;
      check({rq, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      check({rq, " cause"}, 32'(rsp_cause), 32'(ec));
      check({rq, " paddr"}, 32'(rsp_paddr), 32'(ea));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [PA_W-1:0] hold_a;
      logic [2:0] hold_c;
      void'($urandom(32'd1234));
      for (int i = 0; i < NSEG; i++) begin
         m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 1'b0; m_perm[i] = '0;
      end
      m_len = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
      check("R1 req_ready", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      do_req("R1 R2 empty table", 0, 0, 0);
      check("R1 cause", 32'(rsp_cause), 32'd1);

      wr_len(4);
      wr_ent(2, 10'h3F0, 16, 1'b1, 3'b011);
      do_req("R6 last byte", 2, 15, 0);
      check("R6 addr 3FF", 32'(rsp_paddr), 32'h3FF);
      do_req("R4 at limit", 2, 16, 0);
      check("R4 cause", 32'(rsp_cause), 32'd3);
      do_req("R7 fault address", 2, 20, 1);
      check("R7 zero", 32'(rsp_paddr), 32'd0);
      wr_ent(1, 10'h3F8, 64, 1'b1, 3'b100);
      do_req("R6 wrap", 1, 10, 2);
      check("R6 wrap addr", 32'(rsp_paddr), 32'h002);
      do_req("R4 full range limit", 1, 63, 2);
      check("R4 full range", 32'(rsp_cause), 32'd0);
      do_req("R5 read on exec-only", 1, 5, 0);
      check("R5 denied", 32'(rsp_cause), 32'd4);
      do_req("R5 reserved kind", 2, 3, 3);
      check("R5 reserved", 32'(rsp_cause), 32'd4);
      do_req("R5 exec on rw", 2, 3, 2);
      wr_ent(3, 10'h100, 0, 1'b0, 3'b000);
      do_req("R3 R8 absent beats limit", 3, 5, 2);
      check("R3 cause", 32'(rsp_cause), 32'd2);
      wr_ent(5, 10'h200, 40, 1'b1, 3'b111);
      do_req("R2 R8 range beats all", 5, 1, 0);
      check("R2 cause", 32'(rsp_cause), 32'd1);
      do_req("R8 limit beats perm", 1, 63, 0);
      wr_ent(1, 10'h3F8, 8, 1'b1, 3'b100);
      do_req("R8 limit beats perm 2", 1, 9, 0);
      check("R8 cause", 32'(rsp_cause), 32'd3);

      // R11: write and request on the same edge
      @(negedge clk);
      wr_len(8);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = 3'd6; tbl_wr_base = 10'h050;
      tbl_wr_limit = 7'd30; tbl_wr_present = 1'b1; tbl_wr_perm = 3'b001;
      req_valid = 1'b1; req_seg = 3'd6; req_ofs = 6'd4; req_acc = 2'd0;
      @(negedge clk);
      tbl_wr_en = 1'b0; req_valid = 1'b0;
      check("R11 same edge old", 32'(rsp_cause), 32'd2);
      m_base[6] = 10'h050; m_lim[6] = 7'd30; m_pres[6] = 1'b1; m_perm[6] = 3'b001;
      do_req("R11 next edge new", 6, 4, 0);
      check("R11 new addr", 32'(rsp_paddr), 32'h054);

      // R9 R10: stall
      @(negedge clk);
      req_valid = 1'b1; req_seg = 3'd6; req_ofs = 6'd1; req_acc = 2'd0; rsp_ready = 1'b0;
      @(negedge clk);
      req_seg = 3'd5; req_ofs = 6'd2;
      check("R9 valid after accept", 32'(rsp_valid), 32'd1);
      check("R9 ready low while stalled", 32'(req_ready), 32'd0);
      hold_a = rsp_paddr; hold_c = rsp_cause;
      check("R9 stall addr", 32'(hold_a), 32'h051);
      repeat (3) @(negedge clk);
      check("R10 held valid", 32'(rsp_valid), 32'd1);
      check("R10 held addr", 32'(rsp_paddr), 32'(hold_a));
      check("R10 held cause", 32'(rsp_cause), 32'(hold_c));
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 next taken", 32'(rsp_paddr), 32'h202);
      @(negedge clk);
      check("R9 drained", 32'(rsp_valid), 32'd0);

      // random traffic
      for (int n = 0; n < 400; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 20)
            wr_ent(int'($urandom_range(0, NSEG-1)), int'($urandom),
                   int'($urandom_range(0, 64)), bit'($urandom_range(0, 3) != 0),
                   int'($urandom_range(0, 7)));
         else if (r < 25)
            wr_len(int'($urandom_range(0, NSEG)));
         else
            do_req("R8 random", int'($urandom_range(0, NSEG-1)),
                   int'($urandom_range(0, 63)), int'($urandom_range(0, 3)));
      end

      repeat (2) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule